// File: doc/BRIEF.md
# Run-Gated Interval Timer

This block is an 8-bit up-counter with a compare value, meant to sit inside a microcontroller peripheral. It raises a periodic interrupt each time the count has reached the programmed compare value. The count moves only on falling edges of a timer clock that is picked elsewhere. That clock reaches the block as a one-cycle strobe in the system clock domain. All state lives on the system clock.

Software starts and stops the counter through a run bit. The run bit does not act on the counter directly. A status flag takes the run request over on timer-clock edges. The first edge after a start only arms the counter. The first edge after a stop is still counted, and only then does the counter halt. A write to the counter register clears the count to zero, whatever data is written. The block reads back the count, the compare value, the run bit and the status flag, and gives a one-cycle interrupt pulse.

Top module: `interval_timer`

## Requirements
- R1: After reset the count reads 00h, the status flag reads 0, the run bit reads 0, the compare value reads FFh and the interrupt is low.
- R2: With the run bit at 1 and the status flag at 0, the next timer-clock strobe sets the status flag to 1 and leaves the count unchanged. The strobe after that adds one to the count.
- R3: A strobe that finds the status flag at 1 and the count equal to the compare value loads the count with 00h and produces the interrupt. Counting then goes on at the following strobes without software action.
- R4: While running, interrupts come exactly (compare + 1) strobes apart, for compare values from 01h to FFh. A counter write starts a fresh interval from 00h.
- R5: After the run bit is written to 0, the next strobe is still processed as a counting edge. It may increment the count, or clear it and produce an interrupt if a match is pending. On that same strobe the status flag drops to 0, and later strobes change nothing.
- R6: Writing the run bit to 1 again keeps the held count. After the arming strobe, counting continues from that value.
- R7: A counter write sets the count to 00h whatever data is written. If a strobe arrives in the same system cycle, the write wins: the count becomes 00h and no interrupt is produced.
- R8: The count and the status flag change only in cycles with a strobe, except for the count change caused by a counter write.
- R9: The interrupt is high for exactly one system cycle. It rises in the cycle after a strobe, and the count reads 00h while it is high.
- R10: Writes to the compare register and to the run bit are read back unchanged on their readback ports from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tck_fall | input | 1 | One-cycle strobe marking a timer-clock falling edge |
| run_wr | input | 1 | Write enable for the run bit |
| run_wdata | input | 1 | New run bit value |
| data_wr | input | 1 | Write enable for the compare register |
| data_wdata | input | 8 | New compare value |
| cnt_wr | input | 1 | Counter write; clears the count to 00h |
| cnt_rd | output | 8 | Current count |
| data_rd | output | 8 | Current compare value |
| run_rd | output | 1 | Current run bit |
| stat_rd | output | 1 | Status flag: 1 while the counter is running |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest situation to reach is a stop request that lands while a match is pending. The count must sit exactly at the compare value when the run bit drops, so that the last counted strobe both clears the count and raises the interrupt. The bench gets there by clearing the counter, stepping exactly the compare number of strobes, and only then writing the run bit to 0. The same counted approach parks the count on the compare value before a counter write is driven in the same cycle as a strobe. Interrupt spacing is swept over small, medium and full-range compare values, and each measured interval is checked against compare plus one.

// File: rtl/tmr_pkg.sv
// Shared types for the interval timer.
// Assumes: a single system clock, with the timer clock delivered as strobes.
package tmr_pkg;

    // Counter run phase, as seen through the status flag.
    typedef enum logic {
        PH_HALT = 1'b0,
        PH_RUN  = 1'b1
    } tmr_phase_e;

    // Per-strobe action that the counter applies.
    typedef struct packed {
        logic step;   // strobe processed as a counting edge
        logic clr;    // software clear in this cycle
    } tmr_cmd_t;

endpackage

// File: rtl/tmr_regs.sv
// Software-visible run bit and compare register.
// Assumes: single-cycle write strobes with data valid in the same cycle.
module tmr_regs #(
    parameter int unsigned W        = 8,
    parameter logic [W-1:0] DATA_RST = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_wr,
    input  logic         run_wdata,
    input  logic         data_wr,
    input  logic [W-1:0] data_wdata,
    output logic         run_q,
    output logic [W-1:0] data_q
);

    // Run request bit: written by software, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else if (run_wr) begin
            run_q <= run_wdata;
        end
    end

    // Compare value: reset to all ones, written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= DATA_RST;
        end else if (data_wr) begin
            data_q <= data_wdata;
        end
    end

endmodule

// File: rtl/tmr_run_sync.sv
// Status flag that hands the run request to the counter on timer-clock strobes.
// The flag is sampled before the strobe, so the arming strobe does not count
// and the strobe that clears the flag still counts.
// Assumes: tck_fall is a one-system-cycle strobe.
module tmr_run_sync
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tck_fall,
    input  logic       run_q,
    output tmr_phase_e phase_q,
    output logic       active
);

    // Phase register: follows the run bit only on strobe cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_HALT;
        end else if (tck_fall) begin
            phase_q <= run_q ? PH_RUN : PH_HALT;
        end
    end

    // Counting is permitted while the phase, before this strobe, is running.
    always_comb begin
        active = (phase_q == PH_RUN);
    end

endmodule

// File: rtl/tmr_counter.sv
// Up-counter with compare. When a counting strobe finds the count at the
// compare value, the count is loaded with zero and a one-cycle interrupt
// is registered. A software clear overrides a strobe in the same cycle.
// Assumes: cmd.step is only high in strobe cycles.
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  tmr_cmd_t     cmd,
    input  logic [W-1:0] cmp,
    output logic [W-1:0] cnt_q,
    output logic         irq_q
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic hit;

    // Match detect against the compare value.
    always_comb begin
        hit = (cnt_q == cmp);
    end

    // Count register: clear wins, otherwise advance or wrap on a match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cmd.clr) begin
            cnt_q <= '0;
        end else if (cmd.step) begin
            cnt_q <= hit ? '0 : cnt_q + ONE;
        end
    end

    // Interrupt pulse: set for one cycle by a matching counting strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= cmd.step && !cmd.clr && hit;
        end
    end

endmodule

// File: rtl/interval_timer.sv
// Top of the run-gated interval timer: registers, run synchroniser and counter.
// Assumes: tck_fall is a synchronous one-cycle strobe. Register writes are
// single-cycle pulses. Compare values are kept in the range 1 to 2**W-1.
module interval_timer
    import tmr_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tck_fall,
    input  logic         run_wr,
    input  logic         run_wdata,
    input  logic         data_wr,
    input  logic [W-1:0] data_wdata,
    input  logic         cnt_wr,
    output logic [W-1:0] cnt_rd,
    output logic [W-1:0] data_rd,
    output logic         run_rd,
    output logic         stat_rd,
    output logic         irq
);

    localparam logic [W-1:0] DATA_RST = '1;

    logic       run_q;
    logic       active;
    tmr_phase_e phase_q;
    tmr_cmd_t   cmd;

    tmr_regs #(.W(W), .DATA_RST(DATA_RST)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_wr     (run_wr),
        .run_wdata  (run_wdata),
        .data_wr    (data_wr),
        .data_wdata (data_wdata),
        .run_q      (run_q),
        .data_q     (data_rd)
    );

    tmr_run_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .tck_fall (tck_fall),
        .run_q    (run_q),
        .phase_q  (phase_q),
        .active   (active)
    );

    // Build the per-cycle counter command from the strobe and the phase.
    always_comb begin
        cmd.step = tck_fall && active;
        cmd.clr  = cnt_wr;
    end

    tmr_counter #(.W(W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .cmp   (data_rd),
        .cnt_q (cnt_rd),
        .irq_q (irq)
    );

    // Readback of the run bit and the status flag.
    always_comb begin
        run_rd  = run_q;
        stat_rd = (phase_q == PH_RUN);
    end

endmodule

// File: rtl/tmr_chk.sv
// Checker for the interval timer, attached to the top through bind.
// Assumes: the same clock and synchronous active-low reset as the top.
module tmr_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tck_fall,
    input logic         cnt_wr,
    input logic [W-1:0] cnt_rd,
    input logic         run_rd,
    input logic         stat_rd,
    input logic         irq
);

    // R8: the status flag changes only after a strobe cycle.
    p_stat_on_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tck_fall) |-> $stable(stat_rd));

    // R8: the count holds without a strobe or a counter write.
    p_cnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tck_fall) && !$past(cnt_wr)) |-> $stable(cnt_rd));

    // R7: a counter write leaves the count at zero and suppresses the interrupt.
    p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cnt_wr) |-> (cnt_rd == '0 && !irq));

    // R2: the arming strobe does not move the count.
    p_arm_no_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tck_fall && !stat_rd && !cnt_wr) |-> $stable(cnt_rd));

    // R9: the interrupt follows a strobe and comes with a zero count.
    p_irq_after_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(tck_fall) && cnt_rd == '0));

    // R5: the status flag takes over the run bit on each strobe.
    p_stat_follows_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tck_fall) |-> (stat_rd == $past(run_rd)));

endmodule

bind interval_timer tmr_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tck_fall (tck_fall),
    .cnt_wr   (cnt_wr),
    .cnt_rd   (cnt_rd),
    .run_rd   (run_rd),
    .stat_rd  (stat_rd),
    .irq      (irq)
);

// File: tb/interval_timer_tb.sv
// Self-checking bench for the interval timer. Expected values are derived
// arithmetically from the requirements.
module interval_timer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tck_fall = 1'b0;
    logic       run_wr = 1'b0;
    logic       run_wdata = 1'b0;
    logic       data_wr = 1'b0;
    logic [7:0] data_wdata = 8'h00;
    logic       cnt_wr = 1'b0;
    logic [7:0] cnt_rd;
    logic [7:0] data_rd;
    logic       run_rd;
    logic       stat_rd;
    logic       irq;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic last_irq;

    always #5 clk = ~clk;

    interval_timer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tck_fall   (tck_fall),
        .run_wr     (run_wr),
        .run_wdata  (run_wdata),
        .data_wr    (data_wr),
        .data_wdata (data_wdata),
        .cnt_wr     (cnt_wr),
        .cnt_rd     (cnt_rd),
        .data_rd    (data_rd),
        .run_rd     (run_rd),
        .stat_rd    (stat_rd),
        .irq        (irq)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One strobe; afterwards irq is sampled in its single high cycle.
    task automatic tick();
        @(negedge clk) tck_fall = 1'b1;
        @(negedge clk) tck_fall = 1'b0;
        last_irq = irq;
        @(negedge clk);
    endtask

    task automatic wr_run(input logic v);
        @(negedge clk) begin run_wr = 1'b1; run_wdata = v; end
        @(negedge clk) run_wr = 1'b0;
    endtask

    task automatic wr_data(input logic [7:0] v);
        @(negedge clk) begin data_wr = 1'b1; data_wdata = v; end
        @(negedge clk) data_wr = 1'b0;
    endtask

    task automatic wr_cnt();
        @(negedge clk) cnt_wr = 1'b1;
        @(negedge clk) cnt_wr = 1'b0;
    endtask

    // Strobes until an interrupt appears; returns the number of strobes used.
    task automatic measure(output int n);
        n = 0;
        do begin
            tick();
            n++;
        end while (!last_irq && n < 300);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        int d_list[6] = '{1, 2, 3, 7, 100, 255};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        check("R1 cnt", cnt_rd, 0);
        check("R1 stat", stat_rd, 0);
        check("R1 run", run_rd, 0);
        check("R1 data", data_rd, 255);
        check("R1 irq", irq, 0);

        // R10: readback of the compare value and the run bit.
        wr_data(8'h5A);
        check("R10 data", data_rd, 'h5A);

        // R5: strobes while halted change nothing.
        tick();
        check("R5 halted cnt", cnt_rd, 0);
        check("R5 halted stat", stat_rd, 0);

        wr_run(1'b1);
        check("R10 run", run_rd, 1);
        check("R8 stat waits for strobe", stat_rd, 0);

        // R2: the first strobe arms, the second counts.
        tick();
        check("R2 arm stat", stat_rd, 1);
        check("R2 arm cnt", cnt_rd, 0);
        tick();
        check("R2 first count", cnt_rd, 1);

        // R8: no change without strobes.
        repeat (10) @(negedge clk);
        check("R8 idle cnt", cnt_rd, 1);
        check("R8 idle stat", stat_rd, 1);

        // R3/R4: interrupt spacing sweep over compare values.
        foreach (d_list[i]) begin
            wr_data(8'(d_list[i]));
            wr_cnt();
            measure(n);
            check("R4 first interval", n, d_list[i] + 1);
            check("R3 cnt after match", cnt_rd, 0);
            measure(n);
            check("R4 second interval", n, d_list[i] + 1);
        end

        // R9: the interrupt is gone one cycle later.
        @(negedge clk);
        check("R9 pulse width", irq, 0);

        // R7: a counter write while counting clears the count.
        wr_data(8'd10);
        wr_cnt();
        repeat (3) tick();
        check("R7 pre-write cnt", cnt_rd, 3);
        wr_cnt();
        check("R7 write clears", cnt_rd, 0);

        // R5: stop latency is one counted strobe.
        repeat (3) tick();
        wr_run(1'b0);
        check("R5 stat still set", stat_rd, 1);
        tick();
        check("R5 last counted edge", cnt_rd, 4);
        check("R5 stat cleared", stat_rd, 0);
        repeat (3) tick();
        check("R5 stopped cnt", cnt_rd, 4);

        // R6: resume from the held count.
        wr_run(1'b1);
        tick();
        check("R6 arm keeps cnt", cnt_rd, 4);
        tick();
        check("R6 resume", cnt_rd, 5);

        // R5: a stop with a pending match still interrupts.
        wr_data(8'd5);
        wr_cnt();
        repeat (5) tick();
        check("R5 parked at match", cnt_rd, 5);
        wr_run(1'b0);
        tick();
        check("R5 pending irq", last_irq, 1);
        check("R5 pending clear", cnt_rd, 0);
        check("R5 pending stat", stat_rd, 0);

        // R7: a counter write in the same cycle as a matching strobe wins.
        wr_run(1'b1);
        tick();
        wr_data(8'd3);
        repeat (3) tick();
        check("R7 parked at match", cnt_rd, 3);
        @(negedge clk) begin tck_fall = 1'b1; cnt_wr = 1'b1; end
        @(negedge clk) begin tck_fall = 1'b0; cnt_wr = 1'b0; end
        check("R7 same-cycle irq", irq, 0);
        check("R7 same-cycle cnt", cnt_rd, 0);
        tick();
        check("R7 counts on", cnt_rd, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule